// File: doc/BRIEF.md
# Buffered SPI Master with In-Buffer Command Word

This block runs one SPI transaction at a time out of a shared byte buffer. Software fills the buffer with a 16-bit command word followed by any outgoing payload, then issues a start command that names one of eight chip-select lines and one of eight settings profiles. The engine decodes the command word, clocks the bytes across the serial lines, writes received bytes back into the buffer and raises a completion status that can be routed to an interrupt line.

Each profile stores a clock phase choice and a prepend count. In a read operation the prepend count lets a short command (for example an address) be sent and a read follow in the same chip-select window. Clock polarity is a single global setting. The serial bit rate is set by an external enable that marks each SCLK half period.

Top module: `bspi_master`

## Requirements
- R1: The command word sits in buffer bytes 0 (bits 15:8) and 1 (bits 7:0); bits 15:13 hold the operation code and bits 12:0 the byte count. Outgoing bytes are read from offset 2 upward and sent MSB first.
- R2: Operation code 2 (write) sends count bytes from offset 2, ignores MISO and the prepend count, and leaves the buffer unchanged.
- R3: Operation code 1 (read-write) sends count bytes from offset 2 and stores the byte received in position j at buffer offset j.
- R4: Operation code 3 (read) with prepend count P sends P bytes from offset 2, then clocks count more bytes with MOSI held at 0; the byte received in position P+j goes to offset j. Both phases use one unbroken chip-select window of 16*(P+count) SCLK edges.
- R5: Operation code 0 and codes 4 to 7 are sleeps: no chip select and no SCLK edge, and completion follows count enable ticks. A transfer code with a total of zero bytes completes in the same way with zero ticks.
- R6: With phase 0, MOSI is valid before the leading SCLK edge and MISO is sampled on it; with phase 1, data is launched on the leading edge and sampled on the trailing edge. SCLK idles at the global polarity level and returns to it at the end.
- R7: Exactly the selected chip-select line goes low at the start, one half period before the first SCLK edge, and returns high one half period after the last edge; all others stay high.
- R8: With the enable high every cycle, the done status is set 16*N+1 cycles after the cycle that samples the start (N = bytes clocked); the busy output is high from the start until that same edge.
- R9: A start command received while busy is ignored: chip select, data and completion time of the running transfer do not change.
- R10: The done status bit is set on completion and cleared by a clear pulse; the interrupt output equals status AND mask.
- R11: Eight profiles each retain their phase and prepend settings until rewritten; the start command picks the profile independently of the chip-select index.
- R12: After reset all chip selects are high, SCLK is at the polarity level, and busy, done and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_we_i | input | 1 | Software buffer write strobe |
| sw_waddr_i | input | 9 | Software buffer write address |
| sw_wdata_i | input | 8 | Software buffer write byte |
| sw_raddr_i | input | 9 | Software buffer read address |
| sw_rdata_o | output | 8 | Software buffer read byte (combinational) |
| prof_we_i | input | 1 | Profile write strobe |
| prof_idx_i | input | 3 | Profile to write |
| prof_cpha_i | input | 1 | Profile clock phase |
| prof_pre_i | input | 4 | Profile prepend count |
| cpol_i | input | 1 | Global clock polarity |
| irq_mask_i | input | 1 | Done interrupt mask |
| irq_clr_i | input | 1 | Done status clear pulse |
| start_i | input | 1 | Start command strobe |
| start_cs_i | input | 3 | Chip-select index for the start |
| start_prof_i | input | 3 | Profile index for the start |
| sclk_en_i | input | 1 | Half-period tick enable |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Chip selects, active low |
| busy_o | output | 1 | Transfer or sleep in progress |
| done_o | output | 1 | Done status bit |
| irq_o | output | 1 | Masked done interrupt |

## Verification
The start is sampled on one rising edge; chip select falls on that edge, the first SCLK edge follows on the next enabled edge, and done and busy change together 16*N+1 enabled edges after the start, so the bench counts cycles from the start strobe to the first falling-edge sample that shows done and compares against 16*N+2 for every vector and sleep case. The slave model watches SCLK and chip select on falling clock edges, halfway between the design's register updates, so captured MOSI bytes and driven MISO bits never race the design. Buffer contents are read back through the software port only after done is seen, and the interrupt output is sampled a fraction of a cycle after changing the mask because it is combinational.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
  localparam int CMD_W   = 16;
  localparam int OPC_LSB = 13;
  localparam int CNT_W   = 13;
  localparam int PRE_W   = 4;

  localparam logic [2:0] OPC_SLEEP = 3'd0;
  localparam logic [2:0] OPC_RDWR  = 3'd1;
  localparam logic [2:0] OPC_WR    = 3'd2;
  localparam logic [2:0] OPC_RD    = 3'd3;

  typedef struct packed {
    logic             cpha;
    logic [PRE_W-1:0] pre;
  } prof_t;
endpackage

// File: rtl/bspi_buf.sv
module bspi_buf #(
  parameter int BYTES = 512,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          sw_we_i,
  input  logic [AW-1:0] sw_waddr_i,
  input  logic [7:0]    sw_wdata_i,
  input  logic [AW-1:0] sw_raddr_i,
  output logic [7:0]    sw_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_waddr_i,
  input  logic [7:0]    eng_wdata_i,
  input  logic [AW-1:0] eng_raddr_i,
  output logic [7:0]    eng_rdata_o,
  output logic [15:0]   cmd_o
);
  logic [7:0] mem_q [BYTES];

  // engine write wins; software must not write while busy
  always_ff @(posedge clk_i) begin
    if (eng_we_i)     mem_q[eng_waddr_i] <= eng_wdata_i;
    else if (sw_we_i) mem_q[sw_waddr_i]  <= sw_wdata_i;
  end

  assign sw_rdata_o  = mem_q[sw_raddr_i];
  assign eng_rdata_o = mem_q[eng_raddr_i];
  assign cmd_o       = {mem_q[0], mem_q[1]};
endmodule

// File: rtl/bspi_prof.sv
module bspi_prof
  import bspi_pkg::*;
#(
  parameter int NPROF = 8,
  parameter int PFW   = $clog2(NPROF)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [PFW-1:0] widx_i,
  input  prof_t          wdata_i,
  input  logic [PFW-1:0] ridx_i,
  output prof_t          rdata_o
);
  prof_t prof_q [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           prof_q[g] <= '0;
      else if (we_i && widx_i == PFW'(g))    prof_q[g] <= wdata_i;
    end
  end

  assign rdata_o = prof_q[ridx_i];

  p_prof_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ridx_i == widx_i) |=> (rdata_o == $past(wdata_i)) || $changed(ridx_i));
endmodule

// File: rtl/bspi_irq.sv
module bspi_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_evt_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic status_o,
  output logic irq_o
);
  logic st_q;

  // completion beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         st_q <= 1'b0;
    else if (done_evt_i) st_q <= 1'b1;
    else if (clr_i)      st_q <= 1'b0;
  end

  assign status_o = st_q;
  assign irq_o    = st_q & mask_i;

  p_done_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i |=> status_o);
  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_evt_i) |=> !status_o);
endmodule

// File: rtl/bspi_engine.sv
module bspi_engine
  import bspi_pkg::*;
#(
  parameter int AW  = 9,
  parameter int NCS = 8,
  parameter int CSW = $clog2(NCS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           cpol_i,
  input  logic           start_i,
  input  logic [CSW-1:0] start_cs_i,
  input  logic [15:0]    cmd_i,
  input  prof_t          prof_i,
  input  logic           miso_i,
  input  logic [7:0]     rd_data_i,
  output logic [AW-1:0]  rd_addr_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [7:0]     wr_data_o,
  output logic           sclk_o,
  output logic           mosi_o,
  output logic [NCS-1:0] cs_no,
  output logic           busy_o,
  output logic           done_evt_o
);
  localparam int TOT_W = CNT_W + 1;
  localparam int E_W   = TOT_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL, S_WAIT} st_e;

  st_e              st_q;
  logic [2:0]       op_q;
  logic             cpha_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [E_W-1:0]   e_q, last_q;
  logic             sclk_q;
  logic [7:0]       tx_q, rx_q;
  logic [NCS-1:0]   cs_n_q;

  logic [2:0]       in_op;
  logic [CNT_W-1:0] in_cnt;
  logic [TOT_W-1:0] in_tot;
  logic             in_xfer;
  logic             idle;
  logic [TOT_W-1:0] byte_idx, fetch_idx, f_pre;
  logic [2:0]       f_op;
  logic [7:0]       tx_byte;
  logic             edge_go, byte_end, last_edge;

  assign in_op   = cmd_i[15:OPC_LSB];
  assign in_cnt  = cmd_i[CNT_W-1:0];
  assign in_tot  = (in_op == OPC_RD) ? TOT_W'(in_cnt) + TOT_W'(prof_i.pre) : TOT_W'(in_cnt);
  assign in_xfer = (in_op == OPC_RDWR || in_op == OPC_WR || in_op == OPC_RD) && (in_tot != '0);

  assign idle      = (st_q == S_IDLE);
  assign byte_idx  = e_q[E_W-1:4];
  assign fetch_idx = idle ? '0 : (cpha_q ? byte_idx : byte_idx + 1'b1);
  assign f_op      = idle ? in_op : op_q;
  assign f_pre     = idle ? TOT_W'(prof_i.pre) : TOT_W'(pre_q);
  assign rd_addr_o = AW'(fetch_idx) + AW'(2);
  assign tx_byte   = (f_op == OPC_RD && fetch_idx >= f_pre) ? 8'h00 : rd_data_i;

  assign edge_go   = (st_q == S_SHIFT) && tick_i;
  assign byte_end  = (e_q[3:0] == 4'hf);
  assign last_edge = (e_q == last_q);

  assign wr_en_o   = edge_go && byte_end &&
                     (op_q == OPC_RDWR || (op_q == OPC_RD && byte_idx >= TOT_W'(pre_q)));
  assign wr_addr_o = (op_q == OPC_RD) ? AW'(byte_idx - TOT_W'(pre_q)) : AW'(byte_idx);
  assign wr_data_o = cpha_q ? {rx_q[6:0], miso_i} : rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OPC_SLEEP;
      cpha_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      e_q    <= '0;
      last_q <= '0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cs_n_q <= '1;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q   <= in_op;
          cpha_q <= prof_i.cpha;
          pre_q  <= prof_i.pre;
          e_q    <= '0;
          sclk_q <= 1'b0;
          rx_q   <= '0;
          if (in_xfer) begin
            st_q   <= S_SHIFT;
            cs_n_q <= ~(NCS'(1) << start_cs_i);
            last_q <= {in_tot - 1'b1, 4'hf};
            tx_q   <= prof_i.cpha ? 8'h00 : tx_byte;
          end else begin
            st_q  <= S_WAIT;
            cnt_q <= (in_op == OPC_RDWR || in_op == OPC_WR || in_op == OPC_RD) ? '0 : in_cnt;
          end
        end
        S_SHIFT: if (tick_i) begin
          sclk_q <= ~sclk_q;
          e_q    <= e_q + 1'b1;
          if (last_edge) st_q <= S_TAIL;
          if (!e_q[0]) begin
            // leading edge
            if (!cpha_q) rx_q <= {rx_q[6:0], miso_i};
            else         tx_q <= (e_q[3:0] == 4'h0) ? tx_byte : {tx_q[6:0], 1'b0};
          end else begin
            // trailing edge
            if (cpha_q)  rx_q <= {rx_q[6:0], miso_i};
            else         tx_q <= byte_end ? tx_byte : {tx_q[6:0], 1'b0};
          end
        end
        S_TAIL: if (tick_i) begin
          cs_n_q <= '1;
          st_q   <= S_IDLE;
        end
        S_WAIT: begin
          if (cnt_q == '0)  st_q  <= S_IDLE;
          else if (tick_i)  cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_evt_o = ((st_q == S_TAIL) && tick_i) || ((st_q == S_WAIT) && (cnt_q == '0));
  assign busy_o     = !idle;
  assign sclk_o     = sclk_q ^ cpol_i;
  assign mosi_o     = tx_q[7];
  assign cs_no      = cs_n_q;

  p_cs_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_q));
  p_idle_cs_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> (&cs_n_q));
  p_wait_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT) |-> ((&cs_n_q) && !sclk_q));
  p_sclk_rest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle || st_q == S_TAIL) |-> !sclk_q);
  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SHIFT && start_i) |=> $stable(cs_n_q));
endmodule

// File: rtl/bspi_master.sv
module bspi_master
  import bspi_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int NUM_CS    = 8,
  parameter int NUM_PROF  = 8,
  localparam int AW  = $clog2(BUF_BYTES),
  localparam int CSW = $clog2(NUM_CS),
  localparam int PFW = $clog2(NUM_PROF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_we_i,
  input  logic [AW-1:0]     sw_waddr_i,
  input  logic [7:0]        sw_wdata_i,
  input  logic [AW-1:0]     sw_raddr_i,
  output logic [7:0]        sw_rdata_o,
  input  logic              prof_we_i,
  input  logic [PFW-1:0]    prof_idx_i,
  input  logic              prof_cpha_i,
  input  logic [PRE_W-1:0]  prof_pre_i,
  input  logic              cpol_i,
  input  logic              irq_mask_i,
  input  logic              irq_clr_i,
  input  logic              start_i,
  input  logic [CSW-1:0]    start_cs_i,
  input  logic [PFW-1:0]    start_prof_i,
  input  logic              sclk_en_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  logic [AW-1:0] eng_raddr, eng_waddr;
  logic [7:0]    eng_rdata, eng_wdata;
  logic          eng_we, done_evt;
  logic [15:0]   cmd;
  prof_t         prof_wr, prof_rd;

  assign prof_wr = '{cpha: prof_cpha_i, pre: prof_pre_i};

  bspi_buf #(.BYTES(BUF_BYTES), .AW(AW)) u_buf (
    .clk_i       (clk_i),
    .sw_we_i     (sw_we_i),
    .sw_waddr_i  (sw_waddr_i),
    .sw_wdata_i  (sw_wdata_i),
    .sw_raddr_i  (sw_raddr_i),
    .sw_rdata_o  (sw_rdata_o),
    .eng_we_i    (eng_we),
    .eng_waddr_i (eng_waddr),
    .eng_wdata_i (eng_wdata),
    .eng_raddr_i (eng_raddr),
    .eng_rdata_o (eng_rdata),
    .cmd_o       (cmd)
  );

  bspi_prof #(.NPROF(NUM_PROF), .PFW(PFW)) u_prof (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prof_we_i),
    .widx_i  (prof_idx_i),
    .wdata_i (prof_wr),
    .ridx_i  (start_prof_i),
    .rdata_o (prof_rd)
  );

  bspi_engine #(.AW(AW), .NCS(NUM_CS), .CSW(CSW)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sclk_en_i),
    .cpol_i     (cpol_i),
    .start_i    (start_i),
    .start_cs_i (start_cs_i),
    .cmd_i      (cmd),
    .prof_i     (prof_rd),
    .miso_i     (miso_i),
    .rd_data_i  (eng_rdata),
    .rd_addr_o  (eng_raddr),
    .wr_en_o    (eng_we),
    .wr_addr_o  (eng_waddr),
    .wr_data_o  (eng_wdata),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_no      (cs_no),
    .busy_o     (busy_o),
    .done_evt_o (done_evt)
  );

  bspi_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_evt_i (done_evt),
    .clr_i      (irq_clr_i),
    .mask_i     (irq_mask_i),
    .status_o   (done_o),
    .irq_o      (irq_o)
  );

  p_busy_until_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/bspi_master_bench.sv
module bspi_master_bench;
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] cnt;
    logic [3:0] pre;
    logic       cpha;
    logic       cpol;
    logic [2:0] cs;
    logic [2:0] prof;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 8'd3, 4'd0,  1'b0, 1'b0, 3'd0, 3'd0, 8'h11},
    '{3'd1, 8'd4, 4'd0,  1'b1, 1'b0, 3'd3, 3'd2, 8'h22},
    '{3'd3, 8'd3, 4'd2,  1'b0, 1'b1, 3'd5, 3'd5, 8'h33},
    '{3'd3, 8'd2, 4'd0,  1'b1, 1'b1, 3'd7, 3'd7, 8'h44},
    '{3'd1, 8'd1, 4'd0,  1'b0, 1'b1, 3'd1, 3'd4, 8'h55},
    '{3'd2, 8'd2, 4'd9,  1'b1, 1'b0, 3'd2, 3'd1, 8'h66},
    '{3'd3, 8'd5, 4'd15, 1'b0, 1'b0, 3'd6, 3'd3, 8'h77}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sw_we_i = 1'b0;
  logic [8:0] sw_waddr_i = '0, sw_raddr_i = '0;
  logic [7:0] sw_wdata_i = '0, sw_rdata_o;
  logic       prof_we_i = 1'b0, prof_cpha_i = 1'b0;
  logic [2:0] prof_idx_i = '0, start_cs_i = '0, start_prof_i = '0;
  logic [3:0] prof_pre_i = '0;
  logic       cpol_i = 1'b0, irq_mask_i = 1'b0, irq_clr_i = 1'b0, start_i = 1'b0;
  logic       sclk_en_i = 1'b1, miso_i = 1'b0;
  logic       sclk_o, mosi_o, busy_o, done_o, irq_o;
  logic [7:0] cs_no;

  int n_chk = 0, n_fail = 0, cyc = 0, en_div = 1;

  bspi_master u_bspi_master (
    .clk_i(clk), .rst_ni(rst_ni),
    .sw_we_i(sw_we_i), .sw_waddr_i(sw_waddr_i), .sw_wdata_i(sw_wdata_i),
    .sw_raddr_i(sw_raddr_i), .sw_rdata_o(sw_rdata_o),
    .prof_we_i(prof_we_i), .prof_idx_i(prof_idx_i), .prof_cpha_i(prof_cpha_i),
    .prof_pre_i(prof_pre_i), .cpol_i(cpol_i), .irq_mask_i(irq_mask_i),
    .irq_clr_i(irq_clr_i), .start_i(start_i), .start_cs_i(start_cs_i),
    .start_prof_i(start_prof_i), .sclk_en_i(sclk_en_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_no(cs_no), .busy_o(busy_o),
    .done_o(done_o), .irq_o(irq_o)
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end
  initial forever begin
    @(negedge clk);
    sclk_en_i = (en_div <= 1) || (cyc % en_div == 0);
  end

  // slave model, evaluated halfway between design edges
  logic       s_cpha = 1'b0, s_cpol = 1'b0;
  logic [7:0] slv_out [32];
  logic [7:0] mosi_cap [32];
  logic [7:0] cap_sr = '0;
  logic       cs_prev = 1'b0, sclk_prev = 1'b0, lead_bad = 1'b0;
  logic [7:0] cs_mask = '0;
  int         bitn = 0, edges = 0;

  function automatic logic slv_bit(int n);
    if (n >= 256) return 1'b0;
    return slv_out[n/8][7 - n%8];
  endfunction

  initial forever begin
    @(negedge clk);
    if (!(&cs_no) && !cs_prev) begin
      bitn = 0;
      if (!s_cpha) miso_i = slv_bit(0);
    end
    if (!(&cs_no)) cs_mask = cs_mask | ~cs_no;
    if (sclk_o != sclk_prev) begin
      edges++;
      if (!cs_prev) lead_bad = 1'b1;
      if ((sclk_prev == s_cpol) ^ s_cpha) begin
        cap_sr = {cap_sr[6:0], mosi_o};
        bitn++;
        if (bitn % 8 == 0 && bitn <= 256) mosi_cap[bitn/8 - 1] = cap_sr;
      end else begin
        miso_i = slv_bit(bitn);
      end
    end
    cs_prev   = !(&cs_no);
    sclk_prev = sclk_o;
  end

  function automatic logic [7:0] txb(logic [7:0] seed, int i);
    return 8'(seed + 8'(i * 37));
  endfunction
  function automatic logic [7:0] slvb(logic [7:0] seed, int j);
    return 8'((seed ^ 8'h5a) + 8'(j * 11));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic buf_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    sw_we_i = 1'b1; sw_waddr_i = 9'(a); sw_wdata_i = d;
    @(negedge clk);
    sw_we_i = 1'b0;
  endtask

  task automatic buf_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    sw_raddr_i = 9'(a);
    #1 d = sw_rdata_o;
  endtask

  task automatic prof_wr(input logic [2:0] idx, input logic cpha, input logic [3:0] pre);
    @(negedge clk);
    prof_we_i = 1'b1; prof_idx_i = idx; prof_cpha_i = cpha; prof_pre_i = pre;
    @(negedge clk);
    prof_we_i = 1'b0;
  endtask

  task automatic launch(input logic [2:0] op, input int cnt, input int pre,
                        input logic cpha, input logic cpol, input logic [2:0] cs,
                        input logic [2:0] prof, input logic [7:0] seed,
                        input bit wprof, output int diff);
    logic [15:0] cmd;
    int ntx, t0, guard;
    cpol_i = cpol; s_cpha = cpha; s_cpol = cpol;
    if (wprof) prof_wr(prof, cpha, 4'(pre));
    cmd = {op, 13'(cnt)};
    buf_wr(0, cmd[15:8]);
    buf_wr(1, cmd[7:0]);
    ntx = (op == 3'd3) ? pre : cnt;
    for (int i = 0; i < ntx; i++) buf_wr(2 + i, txb(seed, i));
    for (int j = 0; j < 32; j++) begin slv_out[j] = slvb(seed, j); mosi_cap[j] = 8'hxx; end
    @(negedge clk);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    edges = 0; cs_mask = '0; lead_bad = 1'b0;
    start_i = 1'b1; start_cs_i = cs; start_prof_i = prof; t0 = cyc;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 20000) begin @(negedge clk); guard++; end
    diff = cyc - t0;
  endtask

  task automatic chk_mosi(input string tag, input logic [2:0] op, input int tot,
                          input int pre, input logic [7:0] seed);
    int bad = -1;
    logic [7:0] exp;
    for (int b = 0; b < tot; b++) begin
      exp = (op == 3'd3 && b >= pre) ? 8'h00 : txb(seed, b);
      if (bad < 0 && mosi_cap[b] !== exp) bad = b;
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, int'(mosi_cap[bad]),
             int'((op == 3'd3 && bad >= pre) ? 8'h00 : txb(seed, bad)));
  endtask

  task automatic chk_rx(input string tag, input logic [2:0] op, input int cnt,
                        input int pre, input logic [7:0] seed);
    logic [7:0] got, exp;
    int bad = 0, ga = 0, ea = 0;
    for (int j = 0; j < cnt; j++) begin
      buf_rd(j, got);
      exp = (op == 3'd1) ? slvb(seed, j) : slvb(seed, pre + j);
      if (bad == 0 && got !== exp) begin bad = 1; ga = int'(got); ea = int'(exp); end
    end
    chk(bad == 0, tag, ga, ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int diff, tot;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cs_no == 8'hff, "R12 cs", int'(cs_no), 255);
    chk(sclk_o == 1'b0 && !busy_o && !done_o && !irq_o, "R12 status",
        int'({sclk_o, busy_o, done_o, irq_o}), 0);

    for (int v = 0; v < NV; v++) begin
      launch(VEC[v].op, int'(VEC[v].cnt), int'(VEC[v].pre), VEC[v].cpha, VEC[v].cpol,
             VEC[v].cs, VEC[v].prof, VEC[v].seed, 1'b1, diff);
      tot = (VEC[v].op == 3'd3) ? int'(VEC[v].pre) + int'(VEC[v].cnt) : int'(VEC[v].cnt);
      chk(diff == 16*tot + 2, "R8 done timing", diff, 16*tot + 2);
      chk(cs_mask == (8'd1 << VEC[v].cs) && !lead_bad, "R7 cs select",
          int'(cs_mask), int'(8'd1 << VEC[v].cs));
      chk(edges == 16*tot && sclk_o == VEC[v].cpol && !busy_o, "R6 edges/idle",
          edges, 16*tot);
      chk_mosi("R1 mosi", VEC[v].op, tot, int'(VEC[v].pre), VEC[v].seed);
      if (VEC[v].op == 3'd1)      chk_rx("R3 rx store", VEC[v].op, int'(VEC[v].cnt), 0, VEC[v].seed);
      else if (VEC[v].op == 3'd3) chk_rx("R4 rx store", VEC[v].op, int'(VEC[v].cnt),
                                         int'(VEC[v].pre), VEC[v].seed);
      else begin
        buf_rd(2 + int'(VEC[v].cnt) - 1, got);
        chk(got == txb(VEC[v].seed, int'(VEC[v].cnt) - 1), "R2 buffer kept",
            int'(got), int'(txb(VEC[v].seed, int'(VEC[v].cnt) - 1)));
        buf_rd(0, got);
        chk(got == {VEC[v].op, 5'd0}, "R2 cmd kept", int'(got), int'({VEC[v].op, 5'd0}));
      end
    end

    // R10 mask and clear
    chk(done_o && !irq_o, "R10 masked", int'({done_o, irq_o}), 2);
    irq_mask_i = 1'b1;
    #1 chk(irq_o, "R10 unmasked", int'(irq_o), 1);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    chk(!done_o && !irq_o, "R10 cleared", int'({done_o, irq_o}), 0);
    irq_mask_i = 1'b0;

    // R5 sleep, undefined code, zero count
    launch(3'd0, 5, 0, 1'b0, 1'b0, 3'd4, 3'd0, 8'h01, 1'b1, diff);
    chk(diff == 7 && cs_mask == 0 && edges == 0, "R5 sleep", diff, 7);
    launch(3'd6, 3, 0, 1'b0, 1'b0, 3'd4, 3'd0, 8'h02, 1'b0, diff);
    chk(diff == 5 && cs_mask == 0 && edges == 0, "R5 other code", diff, 5);
    launch(3'd1, 0, 0, 1'b0, 1'b0, 3'd4, 3'd0, 8'h03, 1'b0, diff);
    chk(diff == 2 && cs_mask == 0 && edges == 0, "R5 zero count", diff, 2);

    // R9 start during a transfer
    fork
      launch(3'd1, 2, 0, 1'b0, 1'b0, 3'd3, 3'd6, 8'h88, 1'b1, diff);
      begin
        wait (busy_o);
        repeat (10) @(negedge clk);
        start_i = 1'b1; start_cs_i = 3'd0; start_prof_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    chk(diff == 34 && cs_mask == 8'h08, "R9 start ignored", diff, 34);
    chk_mosi("R9 data intact", 3'd1, 2, 0, 8'h88);

    // R6 slow enable, phase 1
    en_div = 3;
    launch(3'd1, 2, 0, 1'b1, 1'b0, 3'd2, 3'd6, 8'h99, 1'b1, diff);
    chk(edges == 32 && cs_mask == 8'h04 && !lead_bad, "R6 slow edges", edges, 32);
    chk_mosi("R6 slow mosi", 3'd1, 2, 0, 8'h99);
    chk_rx("R6 slow rx", 3'd1, 2, 0, 8'h99);
    en_div = 1;

    // R11 profile 5 (phase 0, prepend 2) written by vector 2 and kept since
    launch(3'd3, 1, 2, 1'b0, 1'b0, 3'd0, 3'd5, 8'hab, 1'b0, diff);
    chk(edges == 48 && diff == 50, "R11 profile kept", edges, 48);
    chk_mosi("R11 prepend mosi", 3'd3, 3, 2, 8'hab);
    chk_rx("R11 rx", 3'd3, 1, 2, 8'hab);

    summary();
  end
endmodule